// File: doc/BRIEF.md
# Power-Fail Supervisor and Write Lockout

This block supervises a battery-backed static memory. Two analog comparators report their results to it, each on its own asynchronous flag. One flag is high while the supply is above the write-protect trip point. The other is high while the supply is above the lower battery switchover level. A one-cycle millisecond tick is the time base. From these inputs the block produces:

- an active-low reset request with an open-drain style driver;
- a write lockout that gates the memory's chip, write and output enables;
- a battery-connect select;
- a freshness-seal flag that records whether backup has ever been enabled.

When the supply falls below the trip point, the lockout and the reset request assert at once. When the supply comes back, two independent tick timers start together. The lockout timer releases write protection first. The longer reset timer releases the reset request later. A supply drop at any point restarts both timers from zero.

The battery path stays sealed until the supply is first seen above the trip point. After that it follows the switchover comparator. Only a dedicated factory input can seal it again. A `power_good` output is high once both the lockout and the reset request have released.

Top module: `pwr_supervisor`

## Requirements
- R1: Within 4 clock cycles of `vcc_ok_raw` going low, `lockout` is 1, `rst_n_od` is pulled to 0 and `power_good` is 0.
- R2: `rst_n_od` drives 0 while reset is requested and is otherwise high impedance. It is never driven to 1, so with an external pull-up it reads 1 when released.
- R3: After `vcc_ok_raw` rises and settles, `lockout` stays 1 through `LOCK_TICKS`-1 ticks and is 0 within 3 cycles after tick number `LOCK_TICKS`. The default is 125 ticks.
- R4: The reset request stays asserted through `RST_TICKS`-1 ticks and releases within 3 cycles after tick number `RST_TICKS`. The default is 200 ticks, configurable from 150 to 350, and it must exceed `LOCK_TICKS`. The reset request is therefore never released while `lockout` is 1.
- R5: While `lockout` is 1, `mem_ce_n_o`, `mem_we_n_o` and `mem_oe_n_o` are all 1, so memory requests are ignored and the data drivers stay disabled. While `lockout` is 0, these outputs equal the corresponding inputs.
- R6: Until the seal has been released, `batt_sel` is 0 whatever the switchover flag says. The seal is released (`seal_open` becomes 1) the first time `vcc_ok_raw` is seen high.
- R7: `seal_open` stays 1 until `factory_seal` is 1 at a clock edge. `factory_seal` clears it within 3 cycles, and `batt_sel` then returns to 0.
- R8: A drop of `vcc_ok_raw` during the reset stretch restarts both timers from zero. After the supply returns, `lockout` is still 1 after `LOCK_TICKS`-1 further ticks.
- R9: `power_good` is 1 exactly when both `lockout` and the reset request are released.
- R10: With the seal open, `batt_sel` becomes 1 within 4 cycles of `vcc_sw_raw` going low and 0 within 4 cycles of it going high.
- R11: The synchronous `rst` input does not change `seal_open`. It does put `lockout` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| vcc_ok_raw | input | 1 | Asynchronous flag: supply above write-protect trip point |
| vcc_sw_raw | input | 1 | Asynchronous flag: supply above battery switchover level |
| factory_seal | input | 1 | Re-seals the battery path (clears `seal_open`) |
| mem_ce_n_i | input | 1 | Chip enable from host, active low |
| mem_we_n_i | input | 1 | Write enable from host, active low |
| mem_oe_n_i | input | 1 | Output enable from host, active low |
| mem_ce_n_o | output | 1 | Gated chip enable to memory |
| mem_we_n_o | output | 1 | Gated write enable to memory |
| mem_oe_n_o | output | 1 | Gated output enable to memory |
| lockout | output | 1 | Write protection active |
| rst_n_od | inout | 1 | Open-drain reset request, active low |
| batt_sel | output | 1 | Connect battery to memory supply |
| seal_open | output | 1 | Battery backup enabled (freshness seal released) |
| power_good | output | 1 | Lockout and reset both released |

## Verification
The assertions rely on `factory_seal` being held high during the first reset. The seal register has no reset of its own, and this is the only way it gets a defined value. The assertions also take `tick_ms` to be a single-cycle pulse. They take the comparator flags to hold each level for several cycles, so that the two-flop synchronizers pass every change.

The stimulus drives ticks with idle cycles between them. After every comparator change it waits at least four cycles before it issues the next tick or check. It also moves the switchover flag only in the order a real supply ramp would produce.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;
  localparam int FLAG_W   = 2;
  localparam int FLAG_OK  = 0;
  localparam int FLAG_SW  = 1;
endpackage

// File: rtl/sync_bits.sv
module sync_bits #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage[s] <= '0;
        else if (s == 0) stage[s] <= d;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int LIMIT = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIM);
endmodule

// File: rtl/seal_latch.sv
module seal_latch (
  input  logic clk,
  input  logic supply_ok,
  input  logic factory_seal,
  output logic open_q
);
  always_ff @(posedge clk) begin
    if (factory_seal) open_q <= 1'b0;
    else if (supply_ok) open_q <= 1'b1;
  end
endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor #(
  parameter int LOCK_TICKS  = 125,
  parameter int RST_TICKS   = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_ms,
  input  logic vcc_ok_raw,
  input  logic vcc_sw_raw,
  input  logic factory_seal,
  input  logic mem_ce_n_i,
  input  logic mem_we_n_i,
  input  logic mem_oe_n_i,
  output logic mem_ce_n_o,
  output logic mem_we_n_o,
  output logic mem_oe_n_o,
  output logic lockout,
  inout  wire  rst_n_od,
  output logic batt_sel,
  output logic seal_open,
  output logic power_good
);
  import pwr_sup_pkg::*;

  logic [FLAG_W-1:0] raw_flags, sync_flags;
  logic ok_s, sw_s;
  logic lock_done, rst_done;
  logic lockout_q, reset_q, batt_sel_q, seal_q;

  assign raw_flags[FLAG_OK] = vcc_ok_raw;
  assign raw_flags[FLAG_SW] = vcc_sw_raw;

  sync_bits #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .d(raw_flags), .q(sync_flags)
  );
  assign ok_s = sync_flags[FLAG_OK];
  assign sw_s = sync_flags[FLAG_SW];

  tick_timer #(.LIMIT(LOCK_TICKS)) i_lock_tmr (
    .clk(clk), .rst(rst), .run(ok_s), .tick(tick_ms), .done(lock_done)
  );
  tick_timer #(.LIMIT(RST_TICKS)) i_rst_tmr (
    .clk(clk), .rst(rst), .run(ok_s), .tick(tick_ms), .done(rst_done)
  );

  seal_latch i_seal (
    .clk(clk), .supply_ok(ok_s), .factory_seal(factory_seal), .open_q(seal_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lockout_q  <= 1'b1;
      reset_q    <= 1'b1;
      batt_sel_q <= 1'b0;
    end else begin
      lockout_q  <= !(ok_s && lock_done);
      reset_q    <= !(ok_s && rst_done);
      batt_sel_q <= seal_q && !sw_s && !factory_seal;
    end
  end

  assign lockout    = lockout_q;
  assign rst_n_od   = reset_q ? 1'b0 : 1'bz;
  assign batt_sel   = batt_sel_q;
  assign seal_open  = seal_q;
  assign power_good = !lockout_q && !reset_q;
  assign mem_ce_n_o = mem_ce_n_i | lockout_q;
  assign mem_we_n_o = mem_we_n_i | lockout_q;
  assign mem_oe_n_o = mem_oe_n_i | lockout_q;

  p_drop_locks_r1: assert property (@(posedge clk) disable iff (rst)
    !ok_s |=> (lockout_q && reset_q));

  p_lock_first_r4: assert property (@(posedge clk) disable iff (rst)
    !reset_q |-> !lockout_q);

  p_sealed_no_batt_r6: assert property (@(posedge clk) disable iff (rst)
    !seal_q |=> !batt_sel_q);

  p_seal_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (seal_q && !factory_seal) |=> seal_q);

  p_gate_off_r5: assert property (@(posedge clk) disable iff (rst)
    lockout_q |-> (mem_we_n_o && mem_ce_n_o && mem_oe_n_o));
endmodule

// File: tb/test_pwr_supervisor.sv
module test_pwr_supervisor;
  localparam int LOCK = 125;
  localparam int RSTT = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_ms = 1'b0;
  logic vcc_ok_raw = 1'b0, vcc_sw_raw = 1'b0, factory_seal = 1'b1;
  logic ce_i = 1'b0, we_i = 1'b0, oe_i = 1'b0;
  logic ce_o, we_o, oe_o, lockout, batt_sel, seal_open, power_good;
  wire  rst_line;

  pullup (rst_line);

  pwr_supervisor #(.LOCK_TICKS(LOCK), .RST_TICKS(RSTT)) i_pwr_supervisor (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .vcc_ok_raw(vcc_ok_raw),
    .vcc_sw_raw(vcc_sw_raw), .factory_seal(factory_seal),
    .mem_ce_n_i(ce_i), .mem_we_n_i(we_i), .mem_oe_n_i(oe_i),
    .mem_ce_n_o(ce_o), .mem_we_n_o(we_o), .mem_oe_n_o(oe_o),
    .lockout(lockout), .rst_n_od(rst_line), .batt_sel(batt_sel),
    .seal_open(seal_open), .power_good(power_good)
  );

  always #2 clk = ~clk;

  typedef struct {
    string      req;
    logic [7:0] exp;
    logic [7:0] mask;
  } item_t;

  item_t q[$];
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  // vector: {lockout, rst_line, batt_sel, seal_open, power_good, ce_o, we_o, oe_o}
  function automatic logic [7:0] observe();
    return {lockout, rst_line, batt_sel, seal_open, power_good, ce_o, we_o, oe_o};
  endfunction

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if ((observe() & it.mask) !== (it.exp & it.mask)) begin
        failures++;
        $display("FAIL %s actual=%b expected=%b mask=%b", it.req, observe(), it.exp, it.mask);
      end
    end
  end

  task automatic expect_v(input string req, input logic [7:0] exp, input logic [7:0] mask);
    item_t it;
    @(posedge clk);
    it.req = req; it.exp = exp; it.mask = mask;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 tick_ms = 1'b1;
      @(posedge clk); #1 tick_ms = 1'b0;
      @(posedge clk); #1;
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cycles(4);
    #1 rst = 1'b0; factory_seal = 1'b0;
    cycles(4);
    // reset state: locked, reset low, sealed, gates high (R5, R6)
    expect_v("R6 reset state", 8'b1_0_0_0_0_111, 8'hFF);

    // first power-up releases the seal
    vcc_sw_raw = 1'b1; vcc_ok_raw = 1'b1;
    cycles(4);
    expect_v("R6 seal release", 8'b1_0_0_1_0_111, 8'hFF);
    ticks(LOCK - 1);
    cycles(3);
    expect_v("R3 lock held", 8'b1_0_0_1_0_111, 8'hFF);
    ticks(1);
    cycles(3);
    expect_v("R3 lock released", 8'b0_0_0_1_0_000, 8'hFF);
    #1 ce_i = 1'b1; we_i = 1'b0; oe_i = 1'b1;
    expect_v("R5 pass-through", 8'b0_0_0_1_0_101, 8'hFF);
    ticks(RSTT - LOCK - 1);
    cycles(3);
    expect_v("R4 reset held", 8'b0_0_0_1_0_000, 8'b1100_1000);
    ticks(1);
    cycles(3);
    expect_v("R2 reset released", 8'b0_1_0_1_1_000, 8'b1111_1000);
    expect_v("R9 power good", 8'b0000_1000, 8'b0000_1000);

    // drop out of a good state
    #1 vcc_ok_raw = 1'b0;
    cycles(4);
    expect_v("R1 drop locks", 8'b1_0_0_1_0_111, 8'hFF);

    // restart mid-stretch
    #1 vcc_ok_raw = 1'b1;
    cycles(4);
    ticks(LOCK + 5);
    cycles(3);
    expect_v("R8 mid stretch", 8'b0_0_0_1_0_000, 8'b1100_1000);
    #1 vcc_ok_raw = 1'b0;
    cycles(4);
    expect_v("R1 drop in stretch", 8'b1_0_0_0_0_000, 8'b1100_1000);
    #1 vcc_ok_raw = 1'b1;
    cycles(4);
    ticks(LOCK - 1);
    cycles(3);
    expect_v("R8 restart from zero", 8'b1_0_0_0_0_000, 8'b1100_1000);
    ticks(RSTT - LOCK + 1);
    cycles(3);
    expect_v("R9 good after restart", 8'b0_1_0_0_1_000, 8'b1100_1000);

    // battery switchover
    #1 vcc_ok_raw = 1'b0;
    cycles(4);
    #1 vcc_sw_raw = 1'b0;
    cycles(4);
    expect_v("R10 battery on", 8'b0011_0000, 8'b0011_1000);
    #1 vcc_sw_raw = 1'b1;
    cycles(4);
    expect_v("R10 battery off", 8'b0001_0000, 8'b0011_1000);
    #1 vcc_sw_raw = 1'b0;
    cycles(4);
    expect_v("R10 battery on again", 8'b0011_0000, 8'b0011_0000);

    // factory re-seal
    #1 factory_seal = 1'b1;
    cycles(1);
    #1 factory_seal = 1'b0;
    cycles(3);
    expect_v("R7 reseal", 8'b0000_0000, 8'b0011_0000);
    cycles(6);
    expect_v("R6 sealed no battery", 8'b0000_0000, 8'b0011_0000);

    // system reset keeps the seal
    #1 vcc_sw_raw = 1'b1; vcc_ok_raw = 1'b1;
    cycles(4);
    ticks(LOCK + 1);
    cycles(3);
    expect_v("R3 unlocked before rst", 8'b0001_0000, 8'b1001_0000);
    #1 rst = 1'b1;
    cycles(2);
    #1 rst = 1'b0;
    cycles(1);
    expect_v("R11 seal kept lock set", 8'b1001_0000, 8'b1001_0000);

    cycles(3);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule